// File: doc/BRIEF.md
# Blitter command decoder

This block sits between a command fetch path and a 2D drawing engine. Command words arrive one at a time, 32 bits wide, on a valid/ready input. The block picks out each command header and checks it. It then uses the header's length field to gather the operand words that follow. When the last operand has arrived, it presents the whole command at once. Each operand sits on its own named output port, and a single strobe marks the command as ready.

Five commands are understood: setup, text from memory, text with inline data, solid fill and source copy. The inline text command carries a variable number of data words after its two fixed operands. The block announces the command first and then passes those data words out as a counted burst, with a marker on the final word.

A header is malformed if it has a wrong client code, an unknown opcode, a length that does not fit its opcode, or an odd inline data count. Any of these sets a sticky error bit. The block then throws away words until one decodes as a valid header, and decoding resumes from that word.

Top module: `blit_cmd_decoder`

## Requirements
- R1: A word taken while hunting for a header is accepted as a header only if all of the following hold. Bits 31:29 equal 2. Bits 28:22 are one of 0x01 (setup), 0x26 (text from memory), 0x31 (inline text), 0x50 (fill) or 0x53 (copy). Bits 7:0, which hold the total word count minus two, equal 6 for setup and copy, 2 for text from memory and 4 for fill. Any other word sets `err` on the cycle after it is taken, and no command is produced.
- R2: `cmd_kind` reports the command as follows: 0 setup, 1 text from memory, 2 inline text, 3 fill, 4 copy.
- R3: Setup operands arrive in this order: control, clip top-left, clip bottom-right, destination address, background colour, foreground colour (`cmd_color`), pattern address.
- R4: Fill operands arrive in this order: control, destination top-left, destination bottom-right, destination address, fill colour (`cmd_color`).
- R5: Copy operands arrive in this order: control, destination top-left, destination bottom-right, destination address, source top-left, source pitch, source address.
- R6: Text from memory takes destination top-left, destination bottom-right and source address. Inline text takes destination top-left and destination bottom-right. Every field a command does not carry reads zero.
- R7: Header bit 16 drives `cmd_byte_pack`, bit 15 drives `cmd_src_tiled` and bit 11 drives `cmd_dst_tiled`. Bits 21:20 drive `cmd_wmask`.
- R8: `cmd_valid` goes high on the cycle after the last operand is taken. It stays high, with every field unchanged, until a cycle with `cmd_ready` high, and it drops on the cycle after that. With `cmd_ready` held high it is a one-cycle strobe.
- R9: `in_ready` is low while `cmd_valid` is high, so no word is consumed while a command waits.
- R10: For inline text, the header length minus one is the data word count, reported on `cmd_data_words`. Each data word shows on `data_word` with `data_valid` on the cycle after it is taken, in arrival order. `data_last` marks the final one. The data words follow the command strobe, and a count of zero gives no burst.
- R11: An inline text header whose length field is even gives an odd data count. It sets `err` and yields no command.
- R12: `err` stays set until reset. After an error, words are dropped until one passes the R1 header check, and that word starts a normal decode.
- R13: During and right after reset, `in_ready` is 1 and `cmd_valid`, `data_valid` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 32 | Command stream word |
| cmd_valid | output | 1 | Decoded command present |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_kind | output | 3 | Command code (R2) |
| cmd_byte_pack | output | 1 | Byte packing selected |
| cmd_src_tiled | output | 1 | Source tiling enabled |
| cmd_dst_tiled | output | 1 | Destination tiling enabled |
| cmd_wmask | output | 2 | 32-bpp write mask (bit 0 alpha, bit 1 colour) |
| cmd_data_words | output | 8 | Inline data word count |
| cmd_ctrl | output | 32 | Control and destination pitch word |
| cmd_dst_tl | output | 32 | Destination top-left |
| cmd_dst_br | output | 32 | Destination bottom-right |
| cmd_dst_addr | output | 32 | Destination address |
| cmd_src_tl | output | 32 | Source top-left |
| cmd_src_pitch | output | 32 | Source pitch |
| cmd_src_addr | output | 32 | Source address |
| cmd_color | output | 32 | Fill or foreground colour |
| cmd_bg | output | 32 | Background colour |
| cmd_pat_addr | output | 32 | Pattern address |
| cmd_clip_tl | output | 32 | Clip top-left |
| cmd_clip_br | output | 32 | Clip bottom-right |
| data_valid | output | 1 | Inline data word present |
| data_word | output | 32 | Inline data word |
| data_last | output | 1 | Final inline data word |
| err | output | 1 | Sticky malformed-header flag |

## Verification
Three results come from registers, and each is due exactly one cycle after the rising edge that takes the word causing it. The command strobe follows the last operand, the error flag follows a rejected header, and each data strobe follows its data word. Words are driven on falling edges and held until the falling edge after the taking edge. Checks are made at that same falling edge, or after a short settle following it, so each result is sampled in the cycle it is due. The strobe's drop, and the holding of the command during a stall, are checked one falling edge later.

// File: rtl/blit_pkg.sv
// Shared constants, types and slot-to-field mapping for the blitter
// command decoder. Assumes 32-bit command words with the header layout
// fixed by the consumer of the stream.
package blit_pkg;
    parameter int WORD_W  = 32;
    parameter int LEN_W   = 8;
    parameter int SLOT_W  = 3;
    parameter int NFIELD  = 12;

    // header field positions
    parameter int CLIENT_MSB = 31;
    parameter int CLIENT_LSB = 29;
    parameter int OPC_MSB    = 28;
    parameter int OPC_LSB    = 22;
    parameter int WMASK_MSB  = 21;
    parameter int WMASK_LSB  = 20;
    parameter int PACK_BIT   = 16;
    parameter int STILE_BIT  = 15;
    parameter int DTILE_BIT  = 11;

    parameter logic [2:0] CLIENT_2D    = 3'd2;
    parameter logic [6:0] OPC_SETUP    = 7'h01;
    parameter logic [6:0] OPC_TEXT_MEM = 7'h26;
    parameter logic [6:0] OPC_TEXT_IMM = 7'h31;
    parameter logic [6:0] OPC_FILL     = 7'h50;
    parameter logic [6:0] OPC_COPY     = 7'h53;

    typedef enum logic [2:0] {
        K_SETUP    = 3'd0,
        K_TEXT_MEM = 3'd1,
        K_TEXT_IMM = 3'd2,
        K_FILL     = 3'd3,
        K_COPY     = 3'd4
    } kind_e;

    typedef enum logic [3:0] {
        F_CTRL      = 4'd0,
        F_DST_TL    = 4'd1,
        F_DST_BR    = 4'd2,
        F_DST_ADDR  = 4'd3,
        F_SRC_TL    = 4'd4,
        F_SRC_PITCH = 4'd5,
        F_SRC_ADDR  = 4'd6,
        F_COLOR     = 4'd7,
        F_BG        = 4'd8,
        F_PAT       = 4'd9,
        F_CLIP_TL   = 4'd10,
        F_CLIP_BR   = 4'd11,
        F_NONE      = 4'd15
    } field_e;

    typedef struct packed {
        logic       byte_pack;
        logic       src_tiled;
        logic       dst_tiled;
        logic [1:0] wmask;
    } hdr_flags_t;

    // Which named field the operand in a given slot of a command fills.
    function automatic field_e slot_field(kind_e k, logic [SLOT_W-1:0] s);
        field_e f;
        f = F_NONE;
        case (k)
            K_SETUP: case (s)
                3'd0: f = F_CTRL;
                3'd1: f = F_CLIP_TL;
                3'd2: f = F_CLIP_BR;
                3'd3: f = F_DST_ADDR;
                3'd4: f = F_BG;
                3'd5: f = F_COLOR;
                3'd6: f = F_PAT;
                default: f = F_NONE;
            endcase
            K_TEXT_MEM: case (s)
                3'd0: f = F_DST_TL;
                3'd1: f = F_DST_BR;
                3'd2: f = F_SRC_ADDR;
                default: f = F_NONE;
            endcase
            K_TEXT_IMM: case (s)
                3'd0: f = F_DST_TL;
                3'd1: f = F_DST_BR;
                default: f = F_NONE;
            endcase
            K_FILL: case (s)
                3'd0: f = F_CTRL;
                3'd1: f = F_DST_TL;
                3'd2: f = F_DST_BR;
                3'd3: f = F_DST_ADDR;
                3'd4: f = F_COLOR;
                default: f = F_NONE;
            endcase
            K_COPY: case (s)
                3'd0: f = F_CTRL;
                3'd1: f = F_DST_TL;
                3'd2: f = F_DST_BR;
                3'd3: f = F_DST_ADDR;
                3'd4: f = F_SRC_TL;
                3'd5: f = F_SRC_PITCH;
                3'd6: f = F_SRC_ADDR;
                default: f = F_NONE;
            endcase
            default: f = F_NONE;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/blit_hdr_check.sv
// Combinational header classifier. Given the client, opcode, length and
// flag slices of a candidate header word, it reports whether the word is
// a well-formed header, the command kind, the number of operand words
// before the command is complete and the inline data count.
// Assumes the caller only consults it while hunting for a header.
module blit_hdr_check
    import blit_pkg::*;
(
    input  logic [2:0]        client,
    input  logic [6:0]        opcode,
    input  logic [LEN_W-1:0]  len,
    input  logic [1:0]        wmask,
    input  logic              pack_bit,
    input  logic              stile_bit,
    input  logic              dtile_bit,
    output logic              hdr_ok,
    output kind_e             hdr_kind,
    output hdr_flags_t        hdr_flags,
    output logic [SLOT_W-1:0] hdr_n_oper,
    output logic [LEN_W-1:0]  hdr_n_data
);
    logic known;
    logic len_ok;

    // Decode the opcode and check the length against it.
    always_comb begin
        known    = 1'b1;
        len_ok   = 1'b0;
        hdr_kind = K_SETUP;
        case (opcode)
            OPC_SETUP:    begin hdr_kind = K_SETUP;    len_ok = (len == LEN_W'(6)); end
            OPC_TEXT_MEM: begin hdr_kind = K_TEXT_MEM; len_ok = (len == LEN_W'(2)); end
            OPC_TEXT_IMM: begin hdr_kind = K_TEXT_IMM; len_ok = len[0];            end
            OPC_FILL:     begin hdr_kind = K_FILL;     len_ok = (len == LEN_W'(4)); end
            OPC_COPY:     begin hdr_kind = K_COPY;     len_ok = (len == LEN_W'(6)); end
            default:      known = 1'b0;
        endcase
        hdr_ok = (client == CLIENT_2D) && known && len_ok;
    end

    // Derive operand and inline data counts from the length field.
    always_comb begin
        if (hdr_kind == K_TEXT_IMM) begin
            hdr_n_oper = SLOT_W'(2);
            hdr_n_data = len - LEN_W'(1);
        end else begin
            hdr_n_oper = len[SLOT_W-1:0] + SLOT_W'(1);
            hdr_n_data = '0;
        end
    end

    // Collect the header flag bits.
    always_comb begin
        hdr_flags.byte_pack = pack_bit;
        hdr_flags.src_tiled = stile_bit;
        hdr_flags.dst_tiled = dtile_bit;
        hdr_flags.wmask     = wmask;
    end
endmodule

// File: rtl/blit_operand_store.sv
// Register bank holding one word per named operand field. A clear strobe
// zeroes every field at the start of a command; a write strobe loads one
// field chosen by name. Assumes clear and write never coincide.
module blit_operand_store
    import blit_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          wr_en,
    input  field_e                        wr_field,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [NFIELD-1:0][WORD_W-1:0] fields
);
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        // Hold one operand field, zeroed per command, loaded by name.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                fields[g] <= '0;
            end else if (wr_en && (wr_field == field_e'(g))) begin
                fields[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/blit_seq.sv
// Sequencer for the command stream: hunts for headers, counts operand
// slots, raises the command strobe, and passes inline data out as a
// counted burst. Assumes in_word is only meaningful with in_valid high.
module blit_seq
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              cmd_ready,
    input  logic              hdr_ok,
    input  kind_e             hdr_kind,
    input  hdr_flags_t        hdr_flags,
    input  logic [SLOT_W-1:0] hdr_n_oper,
    input  logic [LEN_W-1:0]  hdr_n_data,
    output logic              st_clr,
    output logic              st_wr,
    output field_e            st_field,
    output logic              cmd_valid,
    output kind_e             cmd_kind,
    output hdr_flags_t        cmd_flags,
    output logic [LEN_W-1:0]  cmd_data_words,
    output logic              data_valid,
    output logic [WORD_W-1:0] data_word,
    output logic              data_last,
    output logic              err
);
    typedef enum logic [1:0] { S_HUNT, S_OPER, S_DATA } state_e;

    state_e            state;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] n_oper;
    logic [LEN_W-1:0]  data_left;
    logic              take;
    logic              last_slot;

    assign in_ready  = !cmd_valid;
    assign take      = in_valid && in_ready;
    assign last_slot = (slot == n_oper - SLOT_W'(1));

    // Steer words into the operand store.
    always_comb begin
        st_clr   = take && (state == S_HUNT) && hdr_ok;
        st_wr    = take && (state == S_OPER);
        st_field = slot_field(cmd_kind, slot);
    end

    // Walk header, operand and data phases and produce the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= S_HUNT;
            slot           <= '0;
            n_oper         <= '0;
            data_left      <= '0;
            cmd_valid      <= 1'b0;
            cmd_kind       <= K_SETUP;
            cmd_flags      <= '0;
            cmd_data_words <= '0;
            data_valid     <= 1'b0;
            data_word      <= '0;
            data_last      <= 1'b0;
            err            <= 1'b0;
        end else begin
            data_valid <= 1'b0;
            data_last  <= 1'b0;
            if (cmd_valid && cmd_ready) begin
                cmd_valid <= 1'b0;
            end
            if (take) begin
                case (state)
                    S_HUNT: begin
                        if (hdr_ok) begin
                            cmd_kind       <= hdr_kind;
                            cmd_flags      <= hdr_flags;
                            cmd_data_words <= hdr_n_data;
                            data_left      <= hdr_n_data;
                            n_oper         <= hdr_n_oper;
                            slot           <= '0;
                            state          <= S_OPER;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                    S_OPER: begin
                        if (last_slot) begin
                            cmd_valid <= 1'b1;
                            state     <= (data_left != '0) ? S_DATA : S_HUNT;
                        end else begin
                            slot <= slot + SLOT_W'(1);
                        end
                    end
                    S_DATA: begin
                        data_valid <= 1'b1;
                        data_word  <= in_word;
                        data_last  <= (data_left == LEN_W'(1));
                        data_left  <= data_left - LEN_W'(1);
                        if (data_left == LEN_W'(1)) begin
                            state <= S_HUNT;
                        end
                    end
                    default: state <= S_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/blit_cmd_decoder.sv
// Top of the blitter command decoder. Splits the incoming word into header
// slices for the classifier, feeds the sequencer and operand store, and
// brings the decoded fields out as named ports. Assumes the consumer
// honours cmd_valid/cmd_ready and takes inline data without stalling.
module blit_cmd_decoder
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [2:0]        cmd_kind,
    output logic              cmd_byte_pack,
    output logic              cmd_src_tiled,
    output logic              cmd_dst_tiled,
    output logic [1:0]        cmd_wmask,
    output logic [LEN_W-1:0]  cmd_data_words,
    output logic [WORD_W-1:0] cmd_ctrl,
    output logic [WORD_W-1:0] cmd_dst_tl,
    output logic [WORD_W-1:0] cmd_dst_br,
    output logic [WORD_W-1:0] cmd_dst_addr,
    output logic [WORD_W-1:0] cmd_src_tl,
    output logic [WORD_W-1:0] cmd_src_pitch,
    output logic [WORD_W-1:0] cmd_src_addr,
    output logic [WORD_W-1:0] cmd_color,
    output logic [WORD_W-1:0] cmd_bg,
    output logic [WORD_W-1:0] cmd_pat_addr,
    output logic [WORD_W-1:0] cmd_clip_tl,
    output logic [WORD_W-1:0] cmd_clip_br,
    output logic              data_valid,
    output logic [WORD_W-1:0] data_word,
    output logic              data_last,
    output logic              err
);
    logic                          hdr_ok;
    kind_e                         hdr_kind;
    hdr_flags_t                    hdr_flags;
    logic [SLOT_W-1:0]             hdr_n_oper;
    logic [LEN_W-1:0]              hdr_n_data;
    logic                          st_clr;
    logic                          st_wr;
    field_e                        st_field;
    kind_e                         kind_q;
    hdr_flags_t                    flags_q;
    logic [NFIELD-1:0][WORD_W-1:0] fields;

    blit_hdr_check i_hdr (
        .client     (in_word[CLIENT_MSB:CLIENT_LSB]),
        .opcode     (in_word[OPC_MSB:OPC_LSB]),
        .len        (in_word[LEN_W-1:0]),
        .wmask      (in_word[WMASK_MSB:WMASK_LSB]),
        .pack_bit   (in_word[PACK_BIT]),
        .stile_bit  (in_word[STILE_BIT]),
        .dtile_bit  (in_word[DTILE_BIT]),
        .hdr_ok     (hdr_ok),
        .hdr_kind   (hdr_kind),
        .hdr_flags  (hdr_flags),
        .hdr_n_oper (hdr_n_oper),
        .hdr_n_data (hdr_n_data)
    );

    blit_seq i_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_word        (in_word),
        .cmd_ready      (cmd_ready),
        .hdr_ok         (hdr_ok),
        .hdr_kind       (hdr_kind),
        .hdr_flags      (hdr_flags),
        .hdr_n_oper     (hdr_n_oper),
        .hdr_n_data     (hdr_n_data),
        .st_clr         (st_clr),
        .st_wr          (st_wr),
        .st_field       (st_field),
        .cmd_valid      (cmd_valid),
        .cmd_kind       (kind_q),
        .cmd_flags      (flags_q),
        .cmd_data_words (cmd_data_words),
        .data_valid     (data_valid),
        .data_word      (data_word),
        .data_last      (data_last),
        .err            (err)
    );

    blit_operand_store i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (st_clr),
        .wr_en    (st_wr),
        .wr_field (st_field),
        .wr_data  (in_word),
        .fields   (fields)
    );

    assign cmd_kind      = kind_q;
    assign cmd_byte_pack = flags_q.byte_pack;
    assign cmd_src_tiled = flags_q.src_tiled;
    assign cmd_dst_tiled = flags_q.dst_tiled;
    assign cmd_wmask     = flags_q.wmask;
    assign cmd_ctrl      = fields[F_CTRL];
    assign cmd_dst_tl    = fields[F_DST_TL];
    assign cmd_dst_br    = fields[F_DST_BR];
    assign cmd_dst_addr  = fields[F_DST_ADDR];
    assign cmd_src_tl    = fields[F_SRC_TL];
    assign cmd_src_pitch = fields[F_SRC_PITCH];
    assign cmd_src_addr  = fields[F_SRC_ADDR];
    assign cmd_color     = fields[F_COLOR];
    assign cmd_bg        = fields[F_BG];
    assign cmd_pat_addr  = fields[F_PAT];
    assign cmd_clip_tl   = fields[F_CLIP_TL];
    assign cmd_clip_br   = fields[F_CLIP_BR];
endmodule

// File: rtl/blit_cmd_checker.sv
// Protocol checker for the blitter command decoder, bound to its top.
// Watches only top-level ports; assumes synchronous active-low reset.
module blit_cmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [2:0]  cmd_kind,
    input logic [31:0] cmd_dst_addr,
    input logic [31:0] cmd_ctrl,
    input logic        data_valid,
    input logic        data_last,
    input logic        err
);
    // R8: a stalled command holds and keeps its fields
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind)
            && $stable(cmd_dst_addr) && $stable(cmd_ctrl));

    // R8: a taken command drops on the next cycle
    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_valid);

    // R9: no word is consumed while a command waits, so no data follows
    assert_no_take_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> !data_valid);

    // R10: the last marker only rides on a data word
    assert_last_in_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        data_last |-> data_valid);

    // R10: command and data strobes never overlap
    assert_cmd_data_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && data_valid));

    // R2: only defined command codes appear
    assert_kind_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_kind <= 3'd4);

    // R12: the error flag is sticky
    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind blit_cmd_decoder blit_cmd_checker i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_kind     (cmd_kind),
    .cmd_dst_addr (cmd_dst_addr),
    .cmd_ctrl     (cmd_ctrl),
    .data_valid   (data_valid),
    .data_last    (data_last),
    .err          (err)
);

// File: tb/test_blit_cmd_decoder.sv
// Self-checking bench: a header vector table walked by one loop, then
// directed tests for stall, inline data, odd counts and resynchronisation.
module test_blit_cmd_decoder;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [2:0]  cmd_kind;
    logic        cmd_byte_pack, cmd_src_tiled, cmd_dst_tiled;
    logic [1:0]  cmd_wmask;
    logic [7:0]  cmd_data_words;
    logic [31:0] cmd_ctrl, cmd_dst_tl, cmd_dst_br, cmd_dst_addr;
    logic [31:0] cmd_src_tl, cmd_src_pitch, cmd_src_addr, cmd_color;
    logic [31:0] cmd_bg, cmd_pat_addr, cmd_clip_tl, cmd_clip_br;
    logic        data_valid, data_last, err;
    logic [31:0] data_word;

    int n_chk = 0;
    int n_fail = 0;
    int strobes = 0;
    int dcnt = 0;
    logic [31:0] dbuf [16];
    logic        dlst [16];
    logic [31:0] got [12];

    always #2.5 clk = ~clk;

    blit_cmd_decoder i_blit_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_byte_pack(cmd_byte_pack),
        .cmd_src_tiled(cmd_src_tiled), .cmd_dst_tiled(cmd_dst_tiled),
        .cmd_wmask(cmd_wmask), .cmd_data_words(cmd_data_words),
        .cmd_ctrl(cmd_ctrl), .cmd_dst_tl(cmd_dst_tl), .cmd_dst_br(cmd_dst_br),
        .cmd_dst_addr(cmd_dst_addr), .cmd_src_tl(cmd_src_tl),
        .cmd_src_pitch(cmd_src_pitch), .cmd_src_addr(cmd_src_addr),
        .cmd_color(cmd_color), .cmd_bg(cmd_bg), .cmd_pat_addr(cmd_pat_addr),
        .cmd_clip_tl(cmd_clip_tl), .cmd_clip_br(cmd_clip_br),
        .data_valid(data_valid), .data_word(data_word), .data_last(data_last),
        .err(err)
    );

    // bench field numbering: 0 ctrl 1 dst_tl 2 dst_br 3 dst_addr 4 src_tl
    // 5 src_pitch 6 src_addr 7 color 8 bg 9 pat 10 clip_tl 11 clip_br
    assign got[0] = cmd_ctrl;      assign got[1]  = cmd_dst_tl;
    assign got[2] = cmd_dst_br;    assign got[3]  = cmd_dst_addr;
    assign got[4] = cmd_src_tl;    assign got[5]  = cmd_src_pitch;
    assign got[6] = cmd_src_addr;  assign got[7]  = cmd_color;
    assign got[8] = cmd_bg;        assign got[9]  = cmd_pat_addr;
    assign got[10] = cmd_clip_tl;  assign got[11] = cmd_clip_br;

    // operand order per kind (R3 setup, R6 text, R4 fill, R5 copy)
    localparam int ORD [5][7] = '{
        '{0, 10, 11, 3, 8, 7, 9},
        '{1, 2, 6, -1, -1, -1, -1},
        '{1, 2, -1, -1, -1, -1, -1},
        '{0, 1, 2, 3, 7, -1, -1},
        '{0, 1, 2, 3, 4, 5, 6}
    };
    localparam int NOPS [5] = '{7, 3, 2, 5, 7};

    // header table: word, accepted, expected kind
    localparam int NVEC = 8;
    localparam logic [31:0] VEC_HDR [NVEC] = '{
        32'h4070_0006,  // setup, mask 3
        32'h4981_0802,  // text from memory, byte pack, dst tiled
        32'h5430_0004,  // fill
        32'h54F0_8806,  // copy, both tiled
        32'h4C40_0001,  // inline text, zero data words
        32'h6070_0006,  // client 3: bad
        32'h49C0_0002,  // opcode 0x27: bad
        32'h5430_0005   // fill with wrong length: bad
    };
    localparam bit VEC_OK [NVEC] = '{1, 1, 1, 1, 1, 0, 0, 0};
    localparam int VEC_KIND [NVEC] = '{0, 1, 3, 4, 2, 0, 0, 0};

    // Record command and data strobes seen at falling edges.
    always @(negedge clk) begin
        if (cmd_valid) strobes++;
        if (data_valid) begin
            if (dcnt < 16) begin
                dbuf[dcnt] = data_word;
                dlst[dcnt] = data_last;
            end
            dcnt++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        cmd_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] w);
        in_word = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] exp_f [12];
        logic [31:0] h;
        logic [31:0] held;
        int s0;
        int d0;

        // R13: reset state, checked while reset is held and after it
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R13 in_ready in reset", 32'(in_ready), 32'd1);
        chk("R13 cmd_valid in reset", 32'(cmd_valid), 32'd0);
        do_reset();
        chk("R13 data_valid", 32'(data_valid), 32'd0);
        chk("R13 err", 32'(err), 32'd0);

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8
        for (int e = 0; e < NVEC; e++) begin
            do_reset();
            h = VEC_HDR[e];
            s0 = strobes;
            d0 = dcnt;
            push(h);
            if (VEC_OK[e]) begin
                for (int f = 0; f < 12; f++) exp_f[f] = '0;
                for (int k = 0; k < NOPS[VEC_KIND[e]]; k++) begin
                    logic [31:0] v;
                    v = 32'hC0DE_0000 | (32'(e) << 8) | 32'(k);
                    exp_f[ORD[VEC_KIND[e]][k]] = v;
                    push(v);
                end
                chk("R8 strobe after last operand", 32'(cmd_valid), 32'd1);
                chk("R1 header accepted, no err", 32'(err), 32'd0);
                chk("R2 kind", 32'(cmd_kind), 32'(VEC_KIND[e]));
                chk("R7 flags", {27'd0, cmd_byte_pack, cmd_src_tiled, cmd_dst_tiled, cmd_wmask},
                    {27'd0, h[16], h[15], h[11], h[21:20]});
                for (int f = 0; f < 12; f++)
                    chk($sformatf("R3/R4/R5/R6 field %0d kind %0d", f, VEC_KIND[e]), got[f], exp_f[f]);
                @(negedge clk);
                chk("R8 strobe lasts one cycle", 32'(cmd_valid), 32'd0);
                #1;
                chk("R8 single strobe count", 32'(strobes - s0), 32'd1);
                chk("R10 no burst without data", 32'(dcnt - d0), 32'd0);
            end else begin
                chk("R1 malformed header sets err", 32'(err), 32'd1);
                push(32'h0000_0000);
                #1;
                chk("R1 no command from bad header", 32'(strobes - s0), 32'd0);
            end
        end

        // R8 R9: stall holds command and blocks input
        do_reset();
        cmd_ready = 1'b0;
        push(32'h5430_0004);
        for (int k = 0; k < 5; k++) push(32'hF111_0000 + 32'(k));
        held = cmd_dst_addr;
        chk("R9 in_ready low while command waits", 32'(in_ready), 32'd0);
        in_word = 32'h54F0_8806;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 held under stall", 32'(cmd_valid), 32'd1);
        chk("R8 fields stable under stall", cmd_dst_addr, held);
        chk("R8 kind stable under stall", 32'(cmd_kind), 32'd3);
        in_valid = 1'b0;
        cmd_ready = 1'b1;
        @(negedge clk);
        chk("R8 drop after ready", 32'(cmd_valid), 32'd0);
        chk("R9 in_ready back", 32'(in_ready), 32'd1);
        push(32'h5430_0004);
        for (int k = 0; k < 5; k++) push(32'hF222_0000 + 32'(k));
        chk("R9 stalled word not consumed", 32'(cmd_kind), 32'd3);
        chk("R9 fresh fill decoded", cmd_color, 32'hF222_0004);
        @(negedge clk);

        // R10: inline text with four data words, byte packing
        do_reset();
        s0 = strobes;
        d0 = dcnt;
        push(32'h4C41_0005);
        push(32'h0010_0020);
        push(32'h0050_0060);
        chk("R10 command before data", 32'(cmd_valid), 32'd1);
        chk("R10 data count", 32'(cmd_data_words), 32'd4);
        chk("R2 inline kind", 32'(cmd_kind), 32'd2);
        chk("R7 inline byte pack", 32'(cmd_byte_pack), 32'd1);
        chk("R6 inline dst_br", cmd_dst_br, 32'h0050_0060);
        for (int i = 0; i < 4; i++) push(32'hDA7A_0000 + 32'(i));
        @(negedge clk);
        #1;
        chk("R10 burst length", 32'(dcnt - d0), 32'd4);
        for (int i = 0; i < 4; i++) begin
            chk("R10 data order", dbuf[d0 + i], 32'hDA7A_0000 + 32'(i));
            chk("R10 last marker", 32'(dlst[d0 + i]), (i == 3) ? 32'd1 : 32'd0);
        end
        chk("R10 single command", 32'(strobes - s0), 32'd1);
        chk("R10 no err", 32'(err), 32'd0);

        // R11: odd inline count is an error
        do_reset();
        s0 = strobes;
        push(32'h4C40_0004);
        chk("R11 odd data count sets err", 32'(err), 32'd1);
        push(32'h0001_0002);
        push(32'h0003_0004);
        for (int i = 0; i < 3; i++) push(32'hDA7A_1000 + 32'(i));
        #1;
        chk("R11 no command", 32'(strobes - s0), 32'd0);

        // R12: resync on next valid header, err stays set
        push(32'h1234_5678);
        push(32'h4981_0802);
        push(32'hAAAA_0001);
        push(32'hAAAA_0002);
        push(32'hAAAA_0003);
        chk("R12 resync command", 32'(cmd_valid), 32'd1);
        chk("R12 resync kind", 32'(cmd_kind), 32'd1);
        chk("R12 resync src_addr", cmd_src_addr, 32'hAAAA_0003);
        chk("R12 err sticky", 32'(err), 32'd1);
        @(negedge clk);
        do_reset();
        chk("R12 err cleared by reset", 32'(err), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule